// File: doc/BRIEF.md
# Byte Mailbox Port with Status Handshake

This block is the device end of a byte-wide mailbox reached by a host through two I/O addresses. The host pushes a command packet into the block one byte at a time and pulls a framed response back out. Progress is governed by flags in a status byte: input-full, output-full, a framing flag that marks mode bytes, a ready-for-command flag and a ready-for-data flag. Mode commands written by the host open a packet, close it, or abort everything.

Received payload bytes are held in an internal buffer. When the packet is closed, a built-in echo responder returns them inside a frame. The frame opens with a mode byte and closes with a mode byte, and both carry the framing flag. The responder writes the stored byte count into payload offsets 2 to 5 as a big-endian 32-bit value, so the echoed packet always states its true length. Address 0 is the data register. Address 1 reads as status and, when written, takes a command.

Top module: `mbox_port`

## Requirements
- R1: Status bits are: bit0 output-full, bit1 input-full, bit2 framing flag, bit3 command-held flag, bit4 ready-for-command, bit5 ready-for-data, bits 7:6 zero. After reset the status reads 0x10 and the data register reads 0x00. Address 0 selects data and address 1 selects status/command.
- R2: A host write to either address sets input-full for exactly the following cycle, after which the byte is consumed. While a command byte is held, bit3 is also set.
- R3: Command 0x01 is accepted in any state, including mid-response with no cancel before it. It flushes both buffers and clears ready-for-command and output-full. Ready-for-data rises one cycle after the command is consumed.
- R4: Data bytes written while receiving are stored in order up to DEPTH, and later ones are dropped. Data writes in any other state are ignored.
- R5: Command 0x03 while receiving starts the response and clears ready-for-data. In any other state it is ignored.
- R6: A response presents 0x01 with framing flag and output-full (status 0x05), then each payload byte with output-full only (status 0x01), then 0x03 with status 0x05. After the last byte is read, the status returns to 0x10.
- R7: Payload offsets 2..5, where present, carry the stored byte count big-endian (offset 5 = low byte). All other offsets echo the received bytes.
- R8: A host read of address 0 clears output-full and the framing flag at the next edge. The next response byte appears one cycle later.
- R9: Command 0x22 in any state flushes both buffers and returns to idle. Once it is consumed, the status reads exactly 0x10.
- R10: Command values other than 0x01, 0x03 and 0x22 leave the status and the packet unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | Host write strobe, one byte per cycle |
| io_rd_i | input | 1 | Host read strobe |
| io_addr_i | input | 1 | 0 = data register, 1 = status (read) / command (write) |
| io_wdata_i | input | 8 | Host write byte |
| io_rdata_o | output | 8 | Read byte selected by io_addr_i |

## Verification
A host read that drains output-full can land in the same edge as the consumption of a new 0x01 command, which itself clears output-full and restarts reception. The bench provokes this by writing 0x01 while a response header is pending and strobing a data read in the very next cycle, so that both hit the same edge. The status must then read 0x00 and, one cycle later, 0x20, and the following packet must echo exactly its own bytes with no stale response content.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] CMD_NORMAL = 8'h01;
  localparam logic [7:0] CMD_EOC    = 8'h03;
  localparam logic [7:0] CMD_CANCEL = 8'h22;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_RESP} mbox_state_e;
  typedef enum logic [1:0] {PH_HDR, PH_PAY, PH_END} mbox_phase_e;
endpackage

// File: rtl/mbox_hold.sv
module mbox_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic       ibf_o,
  output logic       is_cmd_o,
  output logic [7:0] byte_o
);
  logic       ibf_q, cmd_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      ibf_q <= wr_i;  // device side always consumes the held byte next cycle
      if (wr_i) begin
        cmd_q  <= addr_i;
        byte_q <= wdata_i;
      end
    end
  end

  assign ibf_o    = ibf_q;
  assign is_cmd_o = cmd_q;
  assign byte_o   = byte_q;
endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       push_i,
  input  logic [7:0] wdata_i,
  input  logic       pop_i,
  output logic [7:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + AW'(1);
    end
  end

  assign rdata_o = mem[rd_ptr_q];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl import mbox_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       take_cmd_i,
  input  logic [7:0] take_byte_i,
  input  logic       host_rd_i,
  input  logic [7:0] fifo_rdata_i,
  output logic       push_o,
  output logic       pop_o,
  output logic       flush_o,
  output logic       obf_o,
  output logic       f0_o,
  output logic       rdy_o,
  output logic       ibr_o,
  output logic [7:0] out_byte_o
);
  localparam int CW = $clog2(DEPTH + 1);

  mbox_state_e   state_q, state_d;
  mbox_phase_e   ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d, idx_q, idx_d;
  logic          obf_q, obf_d, f0_q, f0_d, ibr_q, ibr_d;
  logic [7:0]    out_q, out_d;

  function automatic logic [7:0] pay_byte(input logic [CW-1:0] cnt,
                                          input logic [CW-1:0] idx,
                                          input logic [7:0]    echo);
    logic [31:0] len;
    len = 32'(cnt);
    case (idx)
      CW'(2):  return len[31:24];
      CW'(3):  return len[23:16];
      CW'(4):  return len[15:8];
      CW'(5):  return len[7:0];
      default: return echo;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    obf_d   = obf_q;
    f0_d    = f0_q;
    out_d   = out_q;
    push_o  = 1'b0;
    pop_o   = 1'b0;
    flush_o = 1'b0;

    if (host_rd_i && obf_q) begin
      obf_d = 1'b0;
      f0_d  = 1'b0;
    end

    if (take_i && take_cmd_i) begin
      unique case (take_byte_i)
        CMD_NORMAL, CMD_CANCEL: begin
          state_d = (take_byte_i == CMD_NORMAL) ? ST_RECV : ST_IDLE;
          flush_o = 1'b1;
          cnt_d   = '0;
          obf_d   = 1'b0;
          f0_d    = 1'b0;
        end
        CMD_EOC: begin
          if (state_q == ST_RECV) begin
            state_d = ST_RESP;
            ph_d    = PH_HDR;
            idx_d   = '0;
          end
        end
        default: ;
      endcase
    end else begin
      if (take_i && state_q == ST_RECV && cnt_q < CW'(DEPTH)) begin
        push_o = 1'b1;
        cnt_d  = cnt_q + CW'(1);
      end
      if (state_q == ST_RESP && !obf_q) begin
        unique case (ph_q)
          PH_HDR: begin
            out_d = CMD_NORMAL;
            f0_d  = 1'b1;
            obf_d = 1'b1;
            ph_d  = PH_PAY;
          end
          PH_PAY: begin
            obf_d = 1'b1;
            if (idx_q == cnt_q) begin
              out_d = CMD_EOC;
              f0_d  = 1'b1;
              ph_d  = PH_END;
            end else begin
              out_d = pay_byte(cnt_q, idx_q, fifo_rdata_i);
              f0_d  = 1'b0;
              pop_o = 1'b1;
              idx_d = idx_q + CW'(1);
            end
          end
          default: state_d = ST_IDLE;  // trailer has been read
        endcase
      end
    end

    ibr_d = (state_q == ST_RECV) && (state_d == ST_RECV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_HDR;
      cnt_q   <= '0;
      idx_q   <= '0;
      obf_q   <= 1'b0;
      f0_q    <= 1'b0;
      ibr_q   <= 1'b0;
      out_q   <= 8'h00;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      obf_q   <= obf_d;
      f0_q    <= f0_d;
      ibr_q   <= ibr_d;
      out_q   <= out_d;
    end
  end

  assign obf_o      = obf_q;
  assign f0_o       = f0_q;
  assign rdy_o      = (state_q == ST_IDLE);
  assign ibr_o      = ibr_q;
  assign out_byte_o = out_q;
endmodule

// File: rtl/mbox_port.sv
module mbox_port #(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic       io_addr_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o
);
  logic       ibf, is_cmd, push, pop, flush, obf, f0, rdy, ibr;
  logic [7:0] held, fifo_rdata, out_byte, status_w;

  mbox_hold i_hold (
    .clk_i, .rst_ni,
    .wr_i(io_wr_i), .addr_i(io_addr_i), .wdata_i(io_wdata_i),
    .ibf_o(ibf), .is_cmd_o(is_cmd), .byte_o(held)
  );

  mbox_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(push), .wdata_i(held),
    .pop_i(pop), .rdata_o(fifo_rdata)
  );

  mbox_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni,
    .take_i(ibf), .take_cmd_i(is_cmd), .take_byte_i(held),
    .host_rd_i(io_rd_i && !io_addr_i), .fifo_rdata_i(fifo_rdata),
    .push_o(push), .pop_o(pop), .flush_o(flush),
    .obf_o(obf), .f0_o(f0), .rdy_o(rdy), .ibr_o(ibr),
    .out_byte_o(out_byte)
  );

  assign status_w   = {2'b00, ibr, rdy, ibf & is_cmd, f0, ibf, obf};
  assign io_rdata_o = io_addr_i ? status_w : out_byte;
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       io_wr_i,
  input logic       io_rd_i,
  input logic       io_addr_i,
  input logic [7:0] io_wdata_i,
  input logic [7:0] status_i
);
  p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[7:6] == 2'b00);

  p_ibf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i |=> status_i[1]);

  p_ibf_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> !status_i[1]);

  p_rdy_ibr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_i[4] && status_i[5]));

  p_f0_with_obf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[2] |-> status_i[0]);

  p_obf_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !io_addr_i && status_i[0]) |=> !status_i[0]);

  p_cancel_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i && io_wdata_i == 8'h22) ##1 !io_wr_i |=> status_i == 8'h10);
endmodule

bind mbox_port mbox_port_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_wr_i(io_wr_i), .io_rd_i(io_rd_i),
  .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i), .status_i(status_w)
);

// File: tb/test_mbox_port.sv
`timescale 1ns/1ps
module test_mbox_port;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       io_wr_i = 1'b0, io_rd_i = 1'b0, io_addr_i = 1'b0;
  logic [7:0] io_wdata_i = 8'h00;
  logic [7:0] io_rdata_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] pay [0:63];

  always #2.5 clk_i = ~clk_i;

  mbox_port #(.DEPTH(DEPTH)) i_mbox_port (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic peek(output logic [7:0] v);
    io_addr_i = 1'b1; #1; v = io_rdata_o;
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk_i); io_wr_i = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] v);
    @(negedge clk_i); io_addr_i = a; io_rd_i = 1'b1; #1; v = io_rdata_o;
    @(negedge clk_i); io_rd_i = 1'b0;
  endtask

  task automatic poll(input logic [7:0] mask, input logic [7:0] val, input string req,
                      output logic [7:0] st);
    bit hit;
    hit = 0;
    for (int k = 0; k < 64 && !hit; k++) begin
      host_rd(1'b1, st);
      hit = ((st & mask) == val);
    end
    if (!hit) check(req, st & mask, val);
  endtask

  function automatic logic [7:0] exp_byte(input int i, input int m);
    if (i >= 2 && i <= 5) return 8'(m >> (8 * (5 - i)));
    return pay[i];
  endfunction

  task automatic send_body(input int from, input int n);
    logic [7:0] st;
    for (int i = from; i < n; i++) begin
      poll(8'h02, 8'h00, "R2 input-full", st);
      host_wr(1'b0, pay[i]);
    end
    poll(8'h02, 8'h00, "R2 input-full", st);
    host_wr(1'b1, 8'h03);
  endtask

  task automatic send_pkt(input int n);
    logic [7:0] st;
    host_wr(1'b1, 8'h01);
    poll(8'h20, 8'h20, "R3 ready-for-data", st);
    send_body(0, n);
  endtask

  task automatic recv_pkt(input int n, input bit gap);
    logic [7:0] st, v;
    int m;
    m = (n < DEPTH) ? n : DEPTH;
    poll(8'h01, 8'h01, "R6 header wait", st);
    check("R6 header status", st, 8'h05);
    host_rd(1'b0, v);
    check("R6 header byte", v, 8'h01);
    if (gap) begin
      peek(st); check("R8 obf cleared after read", st, 8'h00);
      @(negedge clk_i); peek(st); check("R8 next byte one cycle later", st, 8'h01);
    end
    for (int i = 0; i < m; i++) begin
      poll(8'h01, 8'h01, "R6 payload wait", st);
      check("R6 payload status", st, 8'h01);
      host_rd(1'b0, v);
      if (i >= 2 && i <= 5) check("R7 length field", v, exp_byte(i, m));
      else check("R4 echoed byte", v, exp_byte(i, m));
    end
    poll(8'h01, 8'h01, "R6 trailer wait", st);
    check("R6 trailer status", st, 8'h05);
    host_rd(1'b0, v);
    check("R6 trailer byte", v, 8'h03);
    poll(8'hFF, 8'h10, "R6 back to idle", st);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, v;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 reset state
    peek(st); check("R1 reset status", st, 8'h10);
    io_addr_i = 1'b0; #1; check("R1 reset data", io_rdata_o, 8'h00);

    // R2/R3 exact cycle of flags
    fill(3);
    host_wr(1'b1, 8'h01);
    peek(st); check("R2 command held", st, 8'h1A);
    @(negedge clk_i); peek(st); check("R3 command taken", st, 8'h00);
    @(negedge clk_i); peek(st); check("R3 ready-for-data rises", st, 8'h20);
    host_wr(1'b0, pay[0]);
    peek(st); check("R2 data held", st, 8'h22);
    @(negedge clk_i); peek(st); check("R2 data consumed", st, 8'h20);
    send_body(1, 3);
    recv_pkt(3, 1'b1);

    // R5 end-of-command and R4 data in idle are ignored
    host_wr(1'b1, 8'h03);
    @(negedge clk_i); peek(st); check("R5 EOC ignored in idle", st, 8'h10);
    host_wr(1'b0, 8'h77);
    @(negedge clk_i); peek(st); check("R4 data ignored in idle", st, 8'h10);

    // R10 unknown command inside a packet
    fill(7);
    host_wr(1'b1, 8'h01);
    poll(8'h20, 8'h20, "R3 ready-for-data", st);
    host_wr(1'b1, 8'h55);
    @(negedge clk_i); peek(st); check("R10 unknown command ignored", st, 8'h20);
    send_body(0, 7);
    recv_pkt(7, 1'b0);

    // R4 overflow beyond DEPTH
    fill(DEPTH + 3);
    send_pkt(DEPTH + 3);
    recv_pkt(DEPTH + 3, 1'b0);

    // R9 cancel mid-response
    fill(8);
    send_pkt(8);
    poll(8'h01, 8'h01, "R6 header wait", st);
    host_rd(1'b0, v);
    poll(8'h01, 8'h01, "R6 payload wait", st);
    host_rd(1'b0, v);
    poll(8'h01, 8'h01, "R6 payload wait", st);
    host_wr(1'b1, 8'h22);
    @(negedge clk_i); peek(st); check("R9 cancel status", st, 8'h10);
    fill(4);
    send_pkt(4);
    recv_pkt(4, 1'b0);

    // R3/R8 restart without cancel, drain read in the same edge
    fill(5);
    send_pkt(5);
    poll(8'h01, 8'h01, "R6 header wait", st);
    @(negedge clk_i); io_addr_i = 1'b1; io_wdata_i = 8'h01; io_wr_i = 1'b1;
    @(negedge clk_i); io_wr_i = 1'b0; io_addr_i = 1'b0; io_rd_i = 1'b1; #1;
    check("R8 header read in collision", io_rdata_o, 8'h01);
    @(negedge clk_i); io_rd_i = 1'b0;
    peek(st); check("R3 restart clears output", st, 8'h00);
    @(negedge clk_i); peek(st); check("R3 restart ready-for-data", st, 8'h20);
    fill(4);
    send_body(0, 4);
    recv_pkt(4, 1'b0);

    // random packets, some preceded by cancel
    for (int t = 0; t < 25; t++) begin
      int n;
      n = $urandom_range(0, DEPTH + 2);
      fill(n);
      if ($urandom_range(0, 1) == 1) begin
        host_wr(1'b1, 8'h22);
        @(negedge clk_i); peek(st); check("R9 cancel status", st, 8'h10);
      end
      send_pkt(n);
      recv_pkt(n, $urandom_range(0, 3) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule